// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Disarm

This block is a free-running supervision counter. Once armed, it counts one step per clock and, if software does not restart it in time, raises a one-clock reset request for the chip's reset logic. Software talks to it through two command strobes, "restart" and "disable". These strobes are qualified by a command-slot strobe that marks each executed command.

The watchdog is armed whenever the block leaves reset. It is armed again each time the system comes back from its low-power backup state, even if software had switched it off before. The only way to switch it off is a strict pair of commands: a disable in one command slot and a restart in the very next command slot. When that pair completes, the enable flag drops to 0. From then on the counter sits at zero until the next reset or backup exit.

Top module: `wdg_sentry`

## Requirements
- R1: After reset is released, `wdt_en_o` is 1, `rst_req_o` is 0 and the counter starts from zero.
- R2: While enabled and not restarted, `rst_req_o` goes high exactly 2^CNT_W clock edges after the counter was last cleared. It stays high for exactly one clock, and the count then starts again from zero, so the timeout repeats with the same period.
- R3: A command slot carrying a restart (`cmd_restart_i`=1, `cmd_disable_i`=0) clears the counter without changing `wdt_en_o`. A restart in the cycle where the counter sits at its terminal value suppresses that timeout.
- R4: A slot carrying only a disable, followed directly by a slot carrying only a restart, clears `wdt_en_o` to 0.
- R5: A slot carrying only a disable does not change `wdt_en_o`. If the next slot carries no command (`cmd_slot_i`=1 with both strobes 0), the pending disable is cancelled, and a later restart only clears the counter.
- R6: While `wdt_en_o` is 0, no reset request is produced and restart commands leave the flag at 0.
- R7: A one-clock pulse on `backup_exit_i` sets `wdt_en_o` to 1, clears the counter and cancels any pending disable. It takes priority over a command in the same cycle.
- R8: A slot carrying both strobes acts as a restart and cancels a pending disable, so it never completes or starts the disarm pair.
- R9: Strobes are ignored while `cmd_slot_i` is 0. Cycles with `cmd_slot_i` at 0 do not count as slots, so they neither cancel nor complete a pending disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_slot_i | input | 1 | Marks a cycle in which a command executes |
| cmd_disable_i | input | 1 | Disable strobe, valid with `cmd_slot_i` |
| cmd_restart_i | input | 1 | Restart strobe, valid with `cmd_slot_i` |
| backup_exit_i | input | 1 | One-clock pulse on return from backup state |
| wdt_en_o | output | 1 | Watchdog enable flag |
| rst_req_o | output | 1 | One-clock reset request on timeout |

## Verification
The bench builds the block with `CNT_W` = 6, which gives a 64-clock timeout. With that setting, several full timeout periods, a restart placed exactly on the terminal count, and long stretches of a disarmed watchdog all fit in a few hundred cycles. The default 16-bit width changes only the period, which the bench derives from the same parameter.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_DIS  = 2'b01,
    CMD_RST  = 2'b10,
    CMD_BOTH = 2'b11
  } wdg_cmd_e;

  function automatic wdg_cmd_e wdg_decode(input logic dis, input logic rst);
    wdg_cmd_e c;
    unique case ({rst, dis})
      2'b00:   c = CMD_NONE;
      2'b01:   c = CMD_DIS;
      2'b10:   c = CMD_RST;
      default: c = CMD_BOTH;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/wdg_seq_det.sv
module wdg_seq_det
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slot_i,
  input  logic dis_i,
  input  logic rst_i,
  input  logic backup_exit_i,
  output logic kill_o,
  output logic clr_o,
  output logic pend_o
);
  wdg_cmd_e cmd;
  logic     pend_q;

  always_comb begin
    cmd    = wdg_decode(dis_i, rst_i);
    kill_o = slot_i && pend_q && (cmd == CMD_RST);
    clr_o  = slot_i && ((cmd == CMD_RST) || (cmd == CMD_BOTH));
    pend_o = pend_q;
  end

  // One slot of memory: a disable stays pending only until the next slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend_q <= 1'b0;
    else if (backup_exit_i) pend_q <= 1'b0;
    else if (slot_i)        pend_q <= (cmd == CMD_DIS);
  end
endmodule

// File: rtl/wdg_arm_flag.sv
module wdg_arm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic kill_i,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_o <= 1'b1;
    else if (arm_i)  en_o <= 1'b1;
    else if (kill_i) en_o <= 1'b0;
  end
endmodule

// File: rtl/wdg_tmo_ctr.sv
module wdg_tmo_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             req_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TERM = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (clr_i || !en_i) begin
        cnt_q <= '0;
      end else if (cnt_q == TERM) begin
        cnt_q <= '0;
        req_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign req_o = req_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdg_sentry.sv
module wdg_sentry #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_slot_i,
  input  logic cmd_disable_i,
  input  logic cmd_restart_i,
  input  logic backup_exit_i,
  output logic wdt_en_o,
  output logic rst_req_o
);
  logic             kill;
  logic             clr;
  logic             dis_pend;
  logic [CNT_W-1:0] cnt_q;

  wdg_seq_det u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_i       (cmd_slot_i),
    .dis_i        (cmd_disable_i),
    .rst_i        (cmd_restart_i),
    .backup_exit_i(backup_exit_i),
    .kill_o       (kill),
    .clr_o        (clr),
    .pend_o       (dis_pend)
  );

  wdg_arm_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (backup_exit_i),
    .kill_i(kill),
    .en_o  (wdt_en_o)
  );

  wdg_tmo_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (wdt_en_o),
    .clr_i(clr || backup_exit_i),
    .req_o(rst_req_o),
    .cnt_o(cnt_q)
  );
endmodule

// File: rtl/wdg_sentry_chk.sv
module wdg_sentry_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_slot_i,
  input logic             cmd_disable_i,
  input logic             cmd_restart_i,
  input logic             backup_exit_i,
  input logic             wdt_en_o,
  input logic             rst_req_o,
  input logic             dis_pend,
  input logic [CNT_W-1:0] cnt_q
);
  p_one_clock_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (cnt_q == '0));

  p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_slot_i && cmd_restart_i) |=> ((cnt_q == '0) && !rst_req_o));

  p_restart_keeps_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_en_o && cmd_slot_i && cmd_restart_i && !cmd_disable_i && !dis_pend) |=> wdt_en_o);

  p_pair_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_pend && cmd_slot_i && cmd_restart_i && !cmd_disable_i && !backup_exit_i) |=> !wdt_en_o);

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en_o |-> (!rst_req_o && (cnt_q == '0)));

  p_stays_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_en_o && !backup_exit_i) |=> !wdt_en_o);

  p_backup_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    backup_exit_i |=> (wdt_en_o && !dis_pend && (cnt_q == '0)));

  p_both_cancels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_slot_i && cmd_restart_i && cmd_disable_i) |=> !dis_pend);

  p_no_slot_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_slot_i && !backup_exit_i) |=> $stable(dis_pend));
endmodule

bind wdg_sentry wdg_sentry_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_slot_i   (cmd_slot_i),
  .cmd_disable_i(cmd_disable_i),
  .cmd_restart_i(cmd_restart_i),
  .backup_exit_i(backup_exit_i),
  .wdt_en_o     (wdt_en_o),
  .rst_req_o    (rst_req_o),
  .dis_pend     (dis_pend),
  .cnt_q        (cnt_q)
);

// File: tb/test_wdg_sentry.sv
module test_wdg_sentry;
  localparam int CNT_W = 6;
  localparam int PER   = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_slot_i = 1'b0;
  logic cmd_disable_i = 1'b0;
  logic cmd_restart_i = 1'b0;
  logic backup_exit_i = 1'b0;
  logic wdt_en_o;
  logic rst_req_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wdg_sentry #(.CNT_W(CNT_W)) i_wdg_sentry (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_slot_i   (cmd_slot_i),
    .cmd_disable_i(cmd_disable_i),
    .cmd_restart_i(cmd_restart_i),
    .backup_exit_i(backup_exit_i),
    .wdt_en_o     (wdt_en_o),
    .rst_req_o    (rst_req_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_slot_i = 1'b0; cmd_disable_i = 1'b0; cmd_restart_i = 1'b0;
    backup_exit_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic d, input logic r);
    cmd_slot_i = 1'b1; cmd_disable_i = d; cmd_restart_i = r;
    @(negedge clk);
    cmd_slot_i = 1'b0; cmd_disable_i = 1'b0; cmd_restart_i = 1'b0;
  endtask

  task automatic count_req(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_req_o) hits++;
    end
  endtask

  task automatic t_reset_and_period();
    do_reset();
    check("R1 enable after reset", wdt_en_o, 1);
    check("R1 no request after reset", rst_req_o, 0);
    step(PER - 1);
    check("R2 no request before terminal", rst_req_o, 0);
    step(1);
    check("R2 request at timeout", rst_req_o, 1);
    step(1);
    check("R2 request lasts one clock", rst_req_o, 0);
    step(PER - 2);
    check("R2 quiet before second timeout", rst_req_o, 0);
    step(1);
    check("R2 second timeout same period", rst_req_o, 1);
  endtask

  task automatic t_restart();
    do_reset();
    step(40);
    cmd(1'b0, 1'b1);
    check("R3 restart keeps enable", wdt_en_o, 1);
    step(PER - 1);
    check("R3 restart delays timeout", rst_req_o, 0);
    step(1);
    check("R3 timeout after restart", rst_req_o, 1);
  endtask

  task automatic t_restart_terminal();
    do_reset();
    step(PER - 1);
    cmd(1'b0, 1'b1);
    check("R3 restart at terminal suppresses request", rst_req_o, 0);
    step(PER - 1);
    check("R3 quiet after terminal restart", rst_req_o, 0);
    step(1);
    check("R3 timeout after terminal restart", rst_req_o, 1);
  endtask

  task automatic t_disarm();
    int hits;
    do_reset();
    step(10);
    cmd(1'b1, 1'b0);
    check("R5 disable alone keeps enable", wdt_en_o, 1);
    cmd(1'b0, 1'b1);
    check("R4 disarm pair clears enable", wdt_en_o, 0);
    count_req(3 * PER, hits);
    check("R6 no request while disarmed", hits, 0);
    cmd(1'b0, 1'b1);
    check("R6 restart leaves flag off", wdt_en_o, 0);
  endtask

  task automatic t_gap_no_slot();
    do_reset();
    cmd(1'b1, 1'b0);
    step(3);
    cmd(1'b0, 1'b1);
    check("R9 non-slot cycles keep pending disable", wdt_en_o, 0);
  endtask

  task automatic t_cancel_idle_slot();
    int hits;
    do_reset();
    cmd(1'b1, 1'b0);
    cmd(1'b0, 1'b0);
    cmd(1'b0, 1'b1);
    check("R5 empty slot cancels disable", wdt_en_o, 1);
    count_req(PER + 6, hits);
    check("R5 still times out after cancel", hits, 1);
  endtask

  task automatic t_both_strobes();
    do_reset();
    cmd(1'b1, 1'b0);
    cmd(1'b1, 1'b1);
    check("R8 both strobes do not disarm", wdt_en_o, 1);
    cmd(1'b0, 1'b1);
    check("R8 both strobes cancel pending", wdt_en_o, 1);
  endtask

  task automatic t_strobes_without_slot();
    do_reset();
    step(30);
    cmd_restart_i = 1'b1; cmd_disable_i = 1'b1;
    step(1);
    cmd_restart_i = 1'b0; cmd_disable_i = 1'b0;
    step(PER - 32);
    check("R9 quiet before unchanged timeout", rst_req_o, 0);
    step(1);
    check("R9 strobes without slot ignored", rst_req_o, 1);
  endtask

  task automatic t_backup_exit();
    do_reset();
    cmd(1'b1, 1'b0);
    cmd(1'b0, 1'b1);
    check("R4 disarmed before backup exit", wdt_en_o, 0);
    backup_exit_i = 1'b1; cmd_slot_i = 1'b1; cmd_disable_i = 1'b1;
    step(1);
    backup_exit_i = 1'b0; cmd_slot_i = 1'b0; cmd_disable_i = 1'b0;
    check("R7 backup exit rearms", wdt_en_o, 1);
    cmd(1'b0, 1'b1);
    check("R7 backup exit drops same-cycle disable", wdt_en_o, 1);
    step(PER - 1);
    check("R7 quiet before timeout after rearm", rst_req_o, 0);
    step(1);
    check("R7 timeout after rearm", rst_req_o, 1);
  endtask

  initial begin
    t_reset_and_period();
    t_restart();
    t_restart_terminal();
    t_disarm();
    t_gap_no_slot();
    t_cancel_idle_slot();
    t_both_strobes();
    t_strobes_without_slot();
    t_backup_exit();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule